// File: doc/BRIEF.md
# Triangle-Ramp PWM Sequencer

This block drives a pulse-width-modulated output whose duty value climbs and falls in a triangle pattern. Each one-cycle tick strobe moves the duty value one step of 2. The value rises from 0 to 100, then falls back to 0, and then the cycle repeats. A two-state direction controller holds the current ramp direction. A step register holds the duty value. A comparator against a free-running 100-cycle counter turns that value into a pulse train. The tick strobe comes from outside the block, so the ramp rate depends on how often it fires.

The comparator takes a new duty value only at the boundary between PWM periods, so no period is ever cut short or stretched by a mid-period update. The reset input is active low. It clears every register at once. Its release passes through a short synchronizer, so all state leaves reset on the same clock edge.

Top module: `tri_pwm_seq`

## Requirements
- R1: While reset is held, the duty output is 0 and the PWM and enable outputs are low. After reset is released, the ramp direction is upward, so the first tick yields duty 2.
- R2: A tick cycle changes the duty output by exactly 2. It adds 2 while ramping up and subtracts 2 while ramping down, and the new value is visible one clock after the tick is sampled.
- R3: On cycles without a tick, the duty output keeps its value.
- R4: The duty output never exceeds 100. A tick taken while the duty value is 100 yields 98.
- R5: The duty output never goes below 0. A tick taken while the duty value is 0 after a descent yields 2.
- R6: The enable output is high from the second clock after internal reset release, and it stays high in both directions.
- R7: Over any 100 consecutive cycles in which the applied duty value D is constant, the PWM output is high for exactly D cycles. Duty 0 keeps it low, and duty 100 keeps it high.
- R8: A change of duty value is applied only at the start of a PWM period. The PWM output rises only on the first cycle of a period, so it rises at most once per period.
- R9: Driving reset low clears the duty, PWM and enable outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset. It asserts asynchronously and its release is synchronized. |
| tick_i | input | 1 | One-cycle step strobe |
| pwm_o | output | 1 | Pulse-width-modulated output |
| pwm_en_o | output | 1 | High whenever the block is out of reset |
| duty_o | output | 7 | Current duty value, from 0 to 100 |

## Verification
The bench walks the ramp all the way to both turnaround points. A direction controller that reacts one cycle late would push the value to 102 or wrap it below 0. PWM high time is counted at duty 0, 2, 14 and 100. An off-by-one compare would leak one high cycle at 0 or drop one at 100. Ticks are also issued in the middle of periods while rising edges are counted. A comparator that applied the new value immediately would produce extra pulses or shift pulse edges. Reset is also pulled between clock edges, and the outputs are checked before the next edge arrives. This exposes any reset that was made synchronous.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/tri_rst_sync.sv
module tri_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  // asserts at once, releases after STAGES edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tri_dir_ctrl.sv
module tri_dir_ctrl
  import tri_pwm_pkg::*;
#(
  parameter int DW  = 7,
  parameter int TOP = 100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DW-1:0]   duty_i,
  output ramp_dir_e       dir_o
);
  localparam logic [DW-1:0] TURN_HI = DW'(TOP - 1);

  ramp_dir_e state_q, state_d;

  // next direction is decided from the current duty value; the step
  // logic uses this decided direction so the bound is never crossed
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DIR_UP: if (duty_i > TURN_HI) state_d = DIR_DN;
      DIR_DN: if (duty_i == '0)     state_d = DIR_UP;
      default: state_d = DIR_UP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DIR_UP;
    else         state_q <= state_d;
  end

  assign dir_o = state_d;
endmodule

// File: rtl/tri_duty_step.sv
module tri_duty_step
  import tri_pwm_pkg::*;
#(
  parameter int DW   = 7,
  parameter int STEP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  ramp_dir_e     dir_i,
  output logic [DW-1:0] duty_o
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  logic [DW-1:0] duty_q, duty_d;
  logic          duty_en;

  assign duty_en = tick_i;

  always_comb begin
    duty_d = duty_q;
    if (dir_i == DIR_UP) duty_d = duty_q + STEP_V;
    else                 duty_d = duty_q - STEP_V;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      duty_q <= '0;
    else if (duty_en) duty_q <= duty_d;
  end

  assign duty_o = duty_q;
endmodule

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen #(
  parameter int DW     = 7,
  parameter int PERIOD = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] duty_i,
  output logic          pwm_o,
  output logic [$clog2(PERIOD)-1:0] cnt_o,
  output logic [DW-1:0] act_o
);
  localparam int CW   = $clog2(PERIOD);
  localparam int CMPW = ((CW > DW) ? CW : DW) + 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] act_q;
  logic          wrap;
  logic          act_en;

  assign wrap   = (cnt_q == LAST);
  assign act_en = wrap;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    if (wrap) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // applied duty is taken only as a new period starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (act_en) act_q <= duty_i;
  end

  assign pwm_o = (CMPW'(cnt_q) < CMPW'(act_q));
  assign cnt_o = cnt_q;
  assign act_o = act_q;
endmodule

// File: rtl/tri_pwm_seq.sv
module tri_pwm_seq
  import tri_pwm_pkg::*;
#(
  parameter int DUTY_W      = 7,
  parameter int DUTY_TOP    = 100,
  parameter int DUTY_STEP   = 2,
  parameter int PWM_PERIOD  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic              pwm_o,
  output logic              pwm_en_o,
  output logic [DUTY_W-1:0] duty_o
);
  localparam int CNT_W = $clog2(PWM_PERIOD);

  logic              rst_n_s;
  ramp_dir_e         ramp_dir;
  logic [DUTY_W-1:0] duty_val;
  logic [CNT_W-1:0]  pwm_cnt;
  logic [DUTY_W-1:0] act_duty;
  logic              en_q;

  tri_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  tri_dir_ctrl #(.DW(DUTY_W), .TOP(DUTY_TOP)) u_dir (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .duty_i(duty_val),
    .dir_o (ramp_dir)
  );

  tri_duty_step #(.DW(DUTY_W), .STEP(DUTY_STEP)) u_step (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .tick_i(tick_i),
    .dir_i (ramp_dir),
    .duty_o(duty_val)
  );

  tri_pwm_gen #(.DW(DUTY_W), .PERIOD(PWM_PERIOD)) u_pwm (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .duty_i(duty_val),
    .pwm_o (pwm_o),
    .cnt_o (pwm_cnt),
    .act_o (act_duty)
  );

  // enable is high in both ramp directions once out of reset
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) en_q <= 1'b0;
    else          en_q <= 1'b1;
  end

  assign pwm_en_o = en_q;
  assign duty_o   = duty_val;
endmodule

// File: rtl/tri_pwm_seq_chk.sv
module tri_pwm_seq_chk #(
  parameter int DW     = 7,
  parameter int TOP    = 100,
  parameter int STEP   = 2,
  parameter int PERIOD = 100,
  parameter int CW     = 7
) (
  input logic          clk_i,
  input logic          rst_ns,
  input logic          tick_i,
  input logic [DW-1:0] duty_i,
  input logic          pwm_i,
  input logic          en_i,
  input logic [CW-1:0] cnt_i,
  input logic [DW-1:0] act_i
);
  // R3
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    (duty_i != $past(duty_i)) |-> $past(tick_i));

  // R2
  duty_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    (duty_i != $past(duty_i)) |->
      ((int'(duty_i) == int'($past(duty_i)) + STEP) ||
       (int'($past(duty_i)) == int'(duty_i) + STEP)));

  // R4
  duty_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    int'(duty_i) <= TOP);

  // R6
  enable_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    1'b1 |=> en_i);

  // R8
  rise_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    $rose(pwm_i) |-> (cnt_i == '0));

  // R7
  zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    (act_i == '0) |-> !pwm_i);

  // R7
  full_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    (int'(act_i) >= PERIOD) |-> pwm_i);
endmodule

bind tri_pwm_seq tri_pwm_seq_chk #(
  .DW(DUTY_W), .TOP(DUTY_TOP), .STEP(DUTY_STEP), .PERIOD(PWM_PERIOD), .CW(CNT_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ns(rst_n_s),
  .tick_i(tick_i),
  .duty_i(duty_o),
  .pwm_i (pwm_o),
  .en_i  (pwm_en_o),
  .cnt_i (pwm_cnt),
  .act_i (act_duty)
);

// File: tb/tri_pwm_seq_tb.sv
module tri_pwm_seq_tb;
  localparam int PER = 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       pwm, en;
  logic [6:0] duty;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  tri_pwm_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .pwm_o(pwm), .pwm_en_o(en), .duty_o(duty)
  );

  // bit 7: tick, bits 6:0: expected duty after that cycle
  localparam bit [7:0] VEC [0:11] = '{
    {1'b1, 7'd2},  {1'b1, 7'd4},  {1'b0, 7'd4},  {1'b1, 7'd6},
    {1'b0, 7'd6},  {1'b0, 7'd6},  {1'b1, 7'd8},  {1'b1, 7'd10},
    {1'b0, 7'd10}, {1'b1, 7'd12}, {1'b0, 7'd12}, {1'b1, 7'd14}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic meas_high(output int n);
    n = 0;
    repeat (2*PER) @(negedge clk);
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (pwm) n++;
    end
  endtask

  initial begin
    #(20*150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int exp;
    int hi;
    int rises;
    logic prev;
    rst_n = 1'b0;
    tick  = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 duty in reset", duty, 0);
    chk("R1 pwm in reset", pwm, 0);
    chk("R1 en in reset", en, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 enable after release", en, 1);

    // vector table: R1 first tick up, R2 steps, R3 holds
    for (int k = 0; k < 12; k++) begin
      tick = VEC[k][7];
      @(negedge clk);
      tick = 1'b0;
      chk(VEC[k][7] ? "R2 tick step" : "R3 hold", duty, int'(VEC[k][6:0]));
    end
    exp = 14;

    meas_high(hi);
    chk("R7 high count at 14", hi, 14);

    while (exp < 100) begin
      step_tick();
      exp += 2;
      chk("R2 ramp up", duty, exp);
    end
    meas_high(hi);
    chk("R7 high count at 100", hi, 100);
    chk("R6 enable at top", en, 1);

    step_tick();
    exp = 98;
    chk("R4 turnaround at top", duty, exp);
    while (exp > 0) begin
      step_tick();
      exp -= 2;
      chk("R2 ramp down", duty, exp);
    end
    chk("R6 enable descending", en, 1);
    meas_high(hi);
    chk("R7 high count at 0", hi, 0);

    step_tick();
    exp = 2;
    chk("R5 turnaround at bottom", duty, exp);
    meas_high(hi);
    chk("R7 high count at 2", hi, 2);

    // R8 ticks mid-period: one rise per period only
    rises = 0;
    @(negedge clk);
    prev = pwm;
    for (int i = 0; i < 3*PER; i++) begin
      @(negedge clk);
      if (pwm && !prev) rises++;
      prev = pwm;
      tick = ((i % 37) == 5);
    end
    tick = 1'b0;
    chk("R8 rises in three periods", rises, 3);

    // R9 async reset between edges
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk("R9 duty cleared without edge", duty, 0);
    chk("R9 en cleared without edge", en, 0);
    chk("R9 pwm cleared without edge", pwm, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step_tick();
    chk("R1 up after reset", duty, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule